// File: doc/BRIEF.md
# Stall-Ordered Synchronized Prescaler Control

This block holds the control word of a sample prescaler that lives in a slow, unrelated clock domain. The prescaler emits a one-cycle sample pulse at a programmable power-of-two rate for a supply monitor. The analog comparator is not part of the block; the pulse output stands in for it. Software writes the control word from the bus clock domain. A toggle handshake carries each write into the slow domain and returns the result. While the handshake is in flight, the `sync_ready` flag is low.

An access to the control word that arrives while a transfer is still in flight is not dropped. The bus is held with `bus_stall` until the transfer ends, and the access then takes effect. Accesses therefore finish in the order they were issued. A read of the control word returns the value that came back from the slow domain. The status, interrupt-enable and interrupt-flag registers stay in the bus domain and never stall. The interrupt flag latches each rising edge of the ready flag while the enable bit is set.

The register map uses a 2-bit address. Address 0 is the control word: bit 0 is the sample enable and bits 4:1 are the rate field D. Address 1 is status, with bit 0 equal to the ready flag (read only). Address 2 is the interrupt enable in bit 0. Address 3 is the interrupt flag in bit 0; writing 1 to it clears the flag. An access completes in the bus cycle in which `bus_sel` is high and `bus_stall` is low.

Top module: `presc_sync_ctl`

## Requirements
- R1: An accepted write to address 0 makes `sync_ready` (and status bit 0) read 0 in the next bus cycle. The flag returns to 1 no earlier than 2 and no later than 20 bus cycles after the write when the slow clock is one third of the bus rate. It never drops without such a write.
- R2: A write to address 0 while `sync_ready` is 0 holds `bus_stall` high until `sync_ready` is 1. The write is then accepted and starts a new transfer.
- R3: A read of address 0 while `sync_ready` is 0 stalls the same way. When it completes it returns the most recently issued control write, so queued accesses complete in issue order.
- R4: Accesses to addresses 1, 2 and 3 never assert `bus_stall`, even during a transfer.
- R5: The interrupt flag (address 3 bit 0, mirrored on `irq`) is set one bus cycle after `sync_ready` rises if the enable (address 2 bit 0) is 1. Writing 1 to address 3 bit 0 clears it.
- R6: With control bit 0 set, `sample_pulse` is high for one slow cycle every 2^(D+1) slow cycles, where D is control bits 4:1.
- R7: With control bit 0 clear, `sample_pulse` stays low.
- R8: Writes to address 1 are ignored: status and control read back unchanged.
- R9: After reset, `sync_ready` is 1, `irq` and `bus_stall` are 0, and addresses 0 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| slow_clk | input | 1 | Prescaler domain clock, unrelated to bus_clk |
| rst_n | input | 1 | Active-low reset for both domains |
| bus_sel | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_sel is high and bus_stall is low |
| bus_stall | output | 1 | Holds the current access |
| sync_ready | output | 1 | 1 when no transfer is in flight |
| irq | output | 1 | Interrupt flag |
| sample_pulse | output | 1 | One-slow-cycle sample trigger |

## Verification
Corrupted handshake state would show up in one of two ways. A toggle pair left unequal keeps `sync_ready` low and `bus_stall` high, and the latency window catches this about twenty bus cycles after the write. An early match lets a stalled access through before its predecessor lands, and the next control read then returns a stale word. A wrong rate field or counter shows up within one pulse interval as a period other than 2^(D+1). A lost edge detector shows up as a missing `irq` one cycle after the ready flag rises.

// File: rtl/presc_pkg.sv
`timescale 1ns/1ps
package presc_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_IEN  = 2'd2,
      REG_FLAG = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/sync_chain.sv
`timescale 1ns/1ps
module sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-2:0], d};
   end

   assign q = sr_q[STAGES-1];
endmodule

// File: rtl/presc_slow_core.sv
`timescale 1ns/1ps
module presc_slow_core #(
   parameter int DIV_W  = 4,
   parameter int STAGES = 2,
   localparam int CTRL_W = DIV_W + 1,
   localparam int CNT_W  = 1 << DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_tgl_i,
   input  logic [CTRL_W-1:0] hold_i,
   output logic              ack_tgl_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              pulse_o
);
   logic              req_s;
   logic              ack_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pulse_q;
   logic              load;
   logic [DIV_W-1:0]  div;
   logic [CNT_W:0]    span;
   logic [CNT_W-1:0]  last;

   sync_chain #(.STAGES(STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl_i), .q(req_s)
   );

   assign load = (req_s != ack_q);
   assign div  = ctrl_q[CTRL_W-1:1];
   assign span = ({{CNT_W{1'b0}}, 1'b1} << ({1'b0, div} + 1'b1));
   assign last = span[CNT_W-1:0] - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         ctrl_q  <= '0;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else if (load) begin
         ack_q   <= req_s;
         ctrl_q  <= hold_i;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else if (ctrl_q[0]) begin
         if (cnt_q == last) begin
            cnt_q   <= '0;
            pulse_q <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            pulse_q <= 1'b0;
         end
      end else begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end
   end

   assign ack_tgl_o = ack_q;
   assign ctrl_o    = ctrl_q;
   assign pulse_o   = pulse_q;

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R7
   pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(ctrl_q[0]));
endmodule

// File: rtl/presc_bus_regs.sv
`timescale 1ns/1ps
module presc_bus_regs
   import presc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 4,
   parameter int STAGES = 2,
   localparam int CTRL_W = DIV_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              stall,
   output logic              ready,
   output logic              irq,
   output logic              req_tgl_o,
   output logic [CTRL_W-1:0] hold_o,
   input  logic              ack_tgl_i,
   input  logic [CTRL_W-1:0] slow_ctrl_i
);
   logic              ack_s;
   logic              req_q, ack_seen_q, ie_q, flag_q, ready_q;
   logic [CTRL_W-1:0] hold_q, mirror_q;
   logic              acc, wr_ctrl, wr_ien, clr_flag, rise;
   logic              unused_wdata;

   sync_chain #(.STAGES(STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tgl_i), .q(ack_s)
   );

   assign ready    = (req_q == ack_seen_q);
   assign stall    = sel && (addr == REG_CTRL) && !ready;
   assign acc      = sel && !stall;
   assign wr_ctrl  = acc && we && (addr == REG_CTRL);
   assign wr_ien   = acc && we && (addr == REG_IEN);
   assign clr_flag = acc && we && (addr == REG_FLAG) && wdata[0];
   assign rise     = ready && !ready_q && ie_q;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         ack_seen_q <= 1'b0;
         hold_q     <= '0;
         mirror_q   <= '0;
         ie_q       <= 1'b0;
         flag_q     <= 1'b0;
         ready_q    <= 1'b1;
      end else begin
         if (wr_ctrl) begin
            req_q  <= ~req_q;
            hold_q <= wdata[CTRL_W-1:0];
         end
         if (ack_s != ack_seen_q) begin
            ack_seen_q <= ack_s;
            mirror_q   <= slow_ctrl_i;
         end
         if (wr_ien) ie_q <= wdata[0];
         flag_q  <= (flag_q && !clr_flag) || rise;
         ready_q <= ready;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTRL: rdata[CTRL_W-1:0] = mirror_q;
         REG_STAT: rdata[0] = ready;
         REG_IEN:  rdata[0] = ie_q;
         default:  rdata[0] = flag_q;
      endcase
   end

   assign irq       = flag_q;
   assign req_tgl_o = req_q;
   assign hold_o    = hold_q;

   // R1
   wr_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> !ready);
   // R2
   stalled_wr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && we && stall) |=> $stable(req_q));
   // R4
   side_regs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && addr != REG_CTRL) |-> !stall);
   // R5
   flag_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(ie_q));
endmodule

// File: rtl/presc_sync_ctl.sv
`timescale 1ns/1ps
module presc_sync_ctl #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 4,
   parameter int STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              slow_clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_stall,
   output logic              sync_ready,
   output logic              irq,
   output logic              sample_pulse
);
   localparam int CTRL_W = DIV_W + 1;

   generate
      if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div
         $error("presc_sync_ctl: DIV_W must be 1..5");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("presc_sync_ctl: DATA_W too narrow for control word");
      end
   endgenerate

   logic              req_tgl, ack_tgl;
   logic [CTRL_W-1:0] hold, slow_ctrl;

   presc_bus_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .STAGES(STAGES)) u_bus (
      .clk(bus_clk), .rst_n(rst_n),
      .sel(bus_sel), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(bus_rdata), .stall(bus_stall), .ready(sync_ready), .irq(irq),
      .req_tgl_o(req_tgl), .hold_o(hold),
      .ack_tgl_i(ack_tgl), .slow_ctrl_i(slow_ctrl)
   );

   presc_slow_core #(.DIV_W(DIV_W), .STAGES(STAGES)) u_slow (
      .clk(slow_clk), .rst_n(rst_n),
      .req_tgl_i(req_tgl), .hold_i(hold),
      .ack_tgl_o(ack_tgl), .ctrl_o(slow_ctrl), .pulse_o(sample_pulse)
   );
endmodule

// File: tb/sim_presc_sync_ctl.sv
`timescale 1ns/1ps
module sim_presc_sync_ctl;
   localparam int DATA_W = 8;
   localparam int MINL = 2;
   localparam int MAXL = 20;

   logic clk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
   logic sel = 1'b0, we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic stall, ready, irq, pulse;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   presc_sync_ctl #(.DATA_W(DATA_W), .DIV_W(4), .STAGES(2)) u0 (
      .bus_clk(clk), .slow_clk(sclk), .rst_n(rst_n),
      .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .bus_stall(stall), .sync_ready(ready),
      .irq(irq), .sample_pulse(pulse)
   );

   always #5 clk = ~clk;
   initial begin
      #3;
      forever #15 sclk = ~sclk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference model, evaluated every bus cycle
   int m_ctrl = 0, m_ie = 0, m_irq = 0, m_wait = 0;
   bit m_busy = 0, m_expect_low = 0, prev_ready = 1, late_flagged = 0;

   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            bit acc;
            int exp_rd;
            bit exp_stall;
            exp_stall = sel && addr == 2'd0 && !ready;
            acc = sel && !stall;
            chk(stall == exp_stall, (addr == 2'd0) ? (we ? "R2" : "R3") : "R4",
                "stall", stall, exp_stall);
            chk(irq == m_irq[0], "R5", "irq", irq, m_irq);
            if (acc && !we) begin
               case (addr)
                  2'd0: exp_rd = m_ctrl;
                  2'd1: exp_rd = ready;
                  2'd2: exp_rd = m_ie;
                  default: exp_rd = m_irq;
               endcase
               chk(rdata == exp_rd[DATA_W-1:0], (addr == 2'd0) ? "R3" : "R8",
                   "read data", rdata, exp_rd);
            end
            if (m_expect_low) begin
               chk(!ready, "R1", "ready after ctrl write", ready, 0);
               m_expect_low = 0;
            end
            if (m_busy) begin
               if (ready) begin
                  chk(m_wait >= MINL, "R1", "sync latency min", m_wait, MINL);
                  m_busy = 0;
               end else begin
                  m_wait++;
                  if (m_wait > MAXL && !late_flagged) begin
                     chk(0, "R1", "sync latency max", m_wait, MAXL);
                     late_flagged = 1;
                  end
               end
            end else if (!ready) begin
               chk(0, "R1", "spurious ready drop", ready, 1);
            end
            // next-state of the model for the coming edge
            m_irq = ((m_irq != 0) && !(acc && we && addr == 2'd3 && wdata[0]))
                    || (ready && !prev_ready && m_ie != 0);
            if (acc && we && addr == 2'd2) m_ie = wdata[0];
            if (acc && we && addr == 2'd0) begin
               m_ctrl = int'(wdata[4:0]);
               m_busy = 1;
               m_wait = 0;
               m_expect_low = 1;
               late_flagged = 0;
            end
            prev_ready = ready;
         end
      end
   end

   task automatic bus_op(input bit w, input logic [1:0] a, input int d,
                         output int stalls, output int rd);
      @(negedge clk);
      sel = 1'b1; we = w; addr = a; wdata = d[DATA_W-1:0];
      stalls = 0;
      #1;
      while (stall && stalls < 100) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      rd = int'(rdata);
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic wait_ready();
      int n;
      n = 0;
      do begin
         @(negedge clk);
         #3;
         n++;
      end while (!ready && n < 100);
   endtask

   task automatic measure(input int exp);
      int n;
      n = 0;
      do begin @(negedge sclk); n++; end while (!pulse && n < 300);
      for (int k = 0; k < 2; k++) begin
         n = 0;
         do begin @(negedge sclk); n++; end while (!pulse && n < 300);
         chk(n == exp, "R6", "pulse period", n, exp);
      end
   endtask

   initial begin
      int st, rd, cnt;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #3;
      // R9 reset state
      chk(ready == 1'b1, "R9", "ready after reset", ready, 1);
      chk(irq == 1'b0, "R9", "irq after reset", irq, 0);
      chk(stall == 1'b0, "R9", "stall after reset", stall, 0);
      bus_op(0, 2'd0, 0, st, rd);
      chk(rd == 0, "R9", "ctrl after reset", rd, 0);
      bus_op(0, 2'd2, 0, st, rd);
      chk(rd == 0, "R9", "ie after reset", rd, 0);

      // R1 / R6: enable, D=1 -> period 4
      bus_op(1, 2'd0, 8'h03, st, rd);
      wait_ready();
      measure(4);

      // R2 / R3 ordering: two writes and a read queued behind a transfer
      bus_op(1, 2'd0, 8'h07, st, rd);
      bus_op(1, 2'd0, 8'h05, st, rd);
      chk(st > 0, "R2", "second write stalled", st, 1);
      bus_op(0, 2'd0, 0, st, rd);
      chk(st > 0, "R3", "read stalled", st, 1);
      chk(rd == 8'h05, "R3", "read returns last write", rd, 5);
      measure(8);

      // R4 / R5: side registers during a transfer, interrupt on completion
      bus_op(1, 2'd0, 8'h0B, st, rd);
      bus_op(1, 2'd2, 1, st, rd);
      chk(st == 0, "R4", "ie write no stall", st, 0);
      bus_op(0, 2'd1, 0, st, rd);
      chk(st == 0, "R4", "status read no stall", st, 0);
      chk(rd == 0, "R4", "status busy", rd, 0);
      wait_ready();
      @(negedge clk); #3;
      chk(irq == 1'b1, "R5", "irq after ready rise", irq, 1);
      bus_op(1, 2'd3, 1, st, rd);
      chk(st == 0, "R4", "flag clear no stall", st, 0);
      @(negedge clk); #3;
      chk(irq == 1'b0, "R5", "irq cleared", irq, 0);
      measure(64);

      // R8: write to status ignored
      bus_op(1, 2'd1, 0, st, rd);
      bus_op(0, 2'd1, 0, st, rd);
      chk(rd == 1, "R8", "status after write", rd, 1);
      bus_op(0, 2'd0, 0, st, rd);
      chk(rd == 8'h0B, "R8", "ctrl after status write", rd, 11);

      // R6 D=0 -> period 2
      bus_op(1, 2'd0, 8'h01, st, rd);
      wait_ready();
      measure(2);

      // R7: disabled, no pulses
      bus_op(1, 2'd0, 8'h08, st, rd);
      wait_ready();
      cnt = 0;
      for (int k = 0; k < 150; k++) begin
         @(negedge sclk);
         if (pulse) cnt++;
      end
      chk(cnt == 0, "R7", "pulses while disabled", cnt, 0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule